// File: doc/BRIEF.md
# PCM Sample FIFO Player

This block buffers raw PCM audio bytes and plays them back as signed 16-bit stereo sample pairs. Software pushes bytes one at a time through a write port into a byte-wide buffer of `DEPTH` bytes, 4096 by default. A playback engine removes whole frames from that buffer at a programmable pace. The default tick is 48828.125 Hz, and a separate strobe marks each base-rate tick. On every tick an 8-bit rate value is added to a phase accumulator. Each time the phase crosses a whole frame, the engine fetches one frame, reassembles it and applies a 4-bit volume. It then presents the result on `out_left`/`out_right` with a one-cycle `out_valid` pulse.

Frames come in four layouts, chosen by two mode pins: mono or stereo, and 8-bit or 16-bit samples. The buffer reports full, empty and low-water status. A flush input discards everything held. If the buffer holds less than a whole frame when a frame falls due, the engine outputs a silent pair and leaves the buffer untouched. A downstream serializer can therefore keep running through an underrun.

Top module: `pcm_player`

## Requirements
- R1: Bytes accepted on `wr_en` are played back in the order written. The buffer holds up to `DEPTH` bytes.
- R2: `full` is 1 exactly when `DEPTH` bytes are held. A write presented while `full` is 1 is discarded and never played.
- R3: `empty` is 1 exactly when no byte is held. The held count never exceeds `DEPTH`.
- R4: `low` is 1 while fewer than `DEPTH/4` bytes are held (1024 by default). It is 0 once at least `DEPTH/4` bytes are held.
- R5: A cycle with `flush` high leaves the buffer empty on the next cycle. A write presented in that same cycle is discarded.
- R6: Each `tick` adds `rate` to a 7-bit phase, and a frame falls due when the sum reaches 128. Rate 128 gives a frame on every tick, 64 on every 2nd tick, 32 on every 4th tick, and 0 gives none. A rate above 128 still yields at most one frame per tick.
- R7: Mode encoding is `stereo` (0 mono, 1 stereo) and `wide` (0 8-bit, 1 16-bit). Frame sizes are 1, 2, 2 and 4 bytes for mono8, stereo8, mono16 and stereo16. A 16-bit sample is stored low byte first. A stereo frame is stored left sample first, then right. A mono sample drives both channels.
- R8: An 8-bit sample is a signed byte placed in bits 15:8 of the 16-bit value, with bits 7:0 zero.
- R9: Volume v scales each sample to floor(s*(v+1)/16), and v = 0 gives 0.
- R10: When a frame falls due and fewer bytes than one frame are held, `out_valid` pulses with both outputs 0. The held bytes are not consumed.
- R11: Each due frame yields exactly one one-cycle `out_valid` pulse, and the outputs hold their value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push `wr_data` into the buffer |
| wr_data | input | 8 | Sample byte to push |
| flush | input | 1 | Discard all buffered bytes |
| stereo | input | 1 | 0 mono, 1 stereo frames |
| wide | input | 1 | 0 8-bit, 1 16-bit samples |
| volume | input | 4 | Playback volume, 0 silent |
| rate | input | 8 | Phase increment per tick, 128 = one frame per tick |
| tick | input | 1 | Base-rate output strobe |
| full | output | 1 | Buffer holds `DEPTH` bytes |
| empty | output | 1 | Buffer holds no bytes |
| low | output | 1 | Buffer below one quarter |
| out_valid | output | 1 | New sample pair on the outputs |
| out_left | output | 16 | Left sample, signed |
| out_right | output | 16 | Right sample, signed |

## Verification
The assertions check the following on every cycle: the held count stays within bounds, no byte is popped from an empty buffer, a full buffer ignores a write, a flush empties the buffer, rate 0 never produces a due frame, rate 128 always does, and an underrun drives a silent pulse. Other behaviour can only be shown by the bench scenarios. These include byte ordering across the four layouts, sign extension of 8-bit data, the exact volume arithmetic, the frame cadence at rates 64 and 32, the low-water edges at 1023 and 1024 bytes, and the fact that an underrun leaves a partial frame intact for the next tick.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  localparam int SAMPLE_W = 16;

  typedef enum logic [1:0] {
    FMT_M8  = 2'b00,
    FMT_S8  = 2'b01,
    FMT_M16 = 2'b10,
    FMT_S16 = 2'b11
  } fmt_e;

  function automatic logic [2:0] frame_bytes(input fmt_e f);
    case (f)
      FMT_M8:  return 3'd1;
      FMT_S16: return 3'd4;
      default: return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          low
);
  localparam int LOW_MARK = DEPTH / 4;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign low   = (count < CW'(LOW_MARK));
  assign wr_ok = wr_en && !full && !flush;
  assign rd_ok = rd_en && !flush;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
    if (rd_en) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      count <= count + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  a_r3_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r1_no_pop_empty: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  a_r2_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && wr_en && !rd_en && !flush) |=> full);
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (empty && !full));
endmodule

// File: rtl/pcm_pacer.sv
module pcm_pacer #(
  parameter int RW = 8,
  localparam int FW = RW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [RW-1:0] rate,
  output logic          due
);
  logic [FW-1:0] phase;
  logic [RW:0]   sum;

  assign sum = {2'b00, phase} + {1'b0, rate};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      due   <= 1'b0;
    end else begin
      due <= tick && (sum >= (RW+1)'(1 << FW));
      if (tick) phase <= sum[FW-1:0];
    end
  end

  a_r6_zero_rate: assert property (@(posedge clk) disable iff (rst)
    (tick && rate == '0) |=> !due);
  a_r6_unit_rate: assert property (@(posedge clk) disable iff (rst)
    (tick && rate == RW'(1 << FW)) |=> due);
endmodule

// File: rtl/pcm_unpack.sv
module pcm_unpack
  import pcm_pkg::*;
#(
  parameter int VW = 4,
  localparam int PW = SAMPLE_W + VW + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                byte_vld,
  input  logic [7:0]          byte_data,
  input  logic [1:0]          slot,
  input  logic                last,
  input  fmt_e                fmt,
  input  logic [VW-1:0]       volume,
  input  logic                silence,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  logic [7:0]          slot_q [4];
  logic                fire_q;
  logic [SAMPLE_W-1:0] raw_l, raw_r;

  function automatic logic [SAMPLE_W-1:0] scale(input logic [SAMPLE_W-1:0] s,
                                                input logic [VW-1:0] v);
    logic [VW:0]          g;
    logic signed [PW-1:0] a, b, p;
    g = {1'b0, v} + 1'b1;
    a = PW'($signed(s));
    b = PW'($signed({1'b0, g}));
    p = (a * b) >>> VW;
    return (v == '0) ? '0 : p[SAMPLE_W-1:0];
  endfunction

  always_comb begin
    case (fmt)
      FMT_M8:  begin raw_l = {slot_q[0], 8'h00};     raw_r = raw_l; end
      FMT_S8:  begin raw_l = {slot_q[0], 8'h00};     raw_r = {slot_q[1], 8'h00}; end
      FMT_M16: begin raw_l = {slot_q[1], slot_q[0]}; raw_r = raw_l; end
      default: begin raw_l = {slot_q[1], slot_q[0]}; raw_r = {slot_q[3], slot_q[2]}; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (byte_vld) slot_q[slot] <= byte_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_q    <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      fire_q    <= byte_vld && last;
      out_valid <= silence || fire_q;
      if (silence) begin
        out_left  <= '0;
        out_right <= '0;
      end else if (fire_q) begin
        out_left  <= scale(raw_l, volume);
        out_right <= scale(raw_r, volume);
      end
    end
  end

  a_r10_silence_zero: assert property (@(posedge clk) disable iff (rst)
    silence |=> (out_valid && out_left == '0 && out_right == '0));
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!silence && !fire_q) |=> ($stable(out_left) && $stable(out_right)));
endmodule

// File: rtl/pcm_player.sv
module pcm_player
  import pcm_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int RW    = 8,
  parameter int VW    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [7:0]          wr_data,
  input  logic                flush,
  input  logic                stereo,
  input  logic                wide,
  input  logic [VW-1:0]       volume,
  input  logic [RW-1:0]       rate,
  input  logic                tick,
  output logic                full,
  output logic                empty,
  output logic                low,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right
);
  localparam int CW = $clog2(DEPTH) + 1;

  typedef enum logic {ST_IDLE, ST_FETCH} state_e;

  state_e        state;
  fmt_e          fmt_live, fmt_q;
  logic [1:0]    issue_q, cap_slot_q;
  logic          pend_q, cap_vld_q, cap_last_q, silence_q;
  logic          due, want, start, under, rd_en, issue_last;
  logic [7:0]    rd_data;
  logic [CW-1:0] count;

  assign fmt_live   = fmt_e'({wide, stereo});
  assign want       = due || pend_q;
  assign start      = (state == ST_IDLE) && want && !flush &&
                      (count >= CW'(frame_bytes(fmt_live)));
  assign under      = (state == ST_IDLE) && want && !flush && !start;
  assign rd_en      = (state == ST_FETCH) && !flush;
  assign issue_last = ({1'b0, issue_q} == frame_bytes(fmt_q) - 3'd1);

  pcm_pacer #(.RW(RW)) u_pacer (
    .clk(clk), .rst(rst), .tick(tick), .rate(rate), .due(due)
  );

  pcm_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .count(count),
    .full(full), .empty(empty), .low(low)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      state      <= ST_IDLE;
      fmt_q      <= FMT_M8;
      issue_q    <= '0;
      pend_q     <= 1'b0;
      cap_vld_q  <= 1'b0;
      cap_slot_q <= '0;
      cap_last_q <= 1'b0;
      silence_q  <= 1'b0;
    end else begin
      cap_vld_q  <= rd_en;
      cap_slot_q <= issue_q;
      cap_last_q <= rd_en && issue_last;
      silence_q  <= under;
      case (state)
        ST_IDLE: begin
          pend_q <= 1'b0;
          if (start) begin
            fmt_q   <= fmt_live;
            issue_q <= '0;
            state   <= ST_FETCH;
          end
        end
        default: begin
          if (due) pend_q <= 1'b1;
          issue_q <= issue_q + 1'b1;
          if (issue_last) state <= ST_IDLE;
        end
      endcase
    end
  end

  pcm_unpack #(.VW(VW)) u_unpack (
    .clk(clk), .rst(rst), .byte_vld(cap_vld_q), .byte_data(rd_data),
    .slot(cap_slot_q), .last(cap_last_q), .fmt(fmt_q), .volume(volume),
    .silence(silence_q), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  a_r10_under_keeps: assert property (@(posedge clk) disable iff (rst)
    (under && !wr_en) |=> !rd_en);
endmodule

// File: tb/test_pcm_player.sv
module test_pcm_player;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        flush = 1'b0;
  logic        stereo = 1'b0;
  logic        wide = 1'b0;
  logic [3:0]  volume = 4'd15;
  logic [7:0]  rate = 8'd128;
  logic        tick = 1'b0;
  logic        full, empty, low, out_valid;
  logic [15:0] out_left, out_right;

  int total = 0;
  int bad = 0;
  logic [7:0] mq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_player i_pcm_player (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .flush(flush),
    .stereo(stereo), .wide(wide), .volume(volume), .rate(rate), .tick(tick),
    .full(full), .empty(empty), .low(low), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int scale(input int s, input int v);
    if (v == 0) return 0;
    return (s * (v + 1)) >>> 4;
  endfunction

  function automatic int sx8(input logic [7:0] b);
    return int'($signed(b)) * 256;
  endfunction

  function automatic int sx16(input logic [7:0] hi, input logic [7:0] lo);
    return int'($signed({hi, lo}));
  endfunction

  task automatic set_fmt(input int f);
    @(negedge clk);
    stereo = f[0];
    wide   = f[1];
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (mq.size() < DEPTH) mq.push_back(b);
  endtask

  // R7 R8 R9 R10: expected pair from the model queue
  task automatic model_frame(input int f, output int l, output int r);
    int n;
    logic [7:0] b [4];
    n = (f == 0) ? 1 : (f == 3) ? 4 : 2;
    l = 0; r = 0;
    if (mq.size() < n) return;
    for (int i = 0; i < n; i++) b[i] = mq.pop_front();
    case (f)
      0: begin l = sx8(b[0]); r = l; end
      1: begin l = sx8(b[0]); r = sx8(b[1]); end
      2: begin l = sx16(b[1], b[0]); r = l; end
      default: begin l = sx16(b[1], b[0]); r = sx16(b[3], b[2]); end
    endcase
    l = scale(l, int'(volume));
    r = scale(r, int'(volume));
  endtask

  task automatic do_tick(output int pulses, output int l, output int r);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    pulses = 0; l = 0; r = 0;
    repeat (16) begin
      @(negedge clk);
      if (out_valid) begin
        pulses++;
        l = int'($signed(out_left));
        r = int'($signed(out_right));
      end
    end
  endtask

  task automatic check_flags();
    check(full == (mq.size() == DEPTH), "R2 full flag", int'(full), int'(mq.size() == DEPTH));
    check(empty == (mq.size() == 0), "R3 empty flag", int'(empty), int'(mq.size() == 0));
    check(low == (mq.size() < DEPTH/4), "R4 low flag", int'(low), int'(mq.size() < DEPTH/4));
  endtask

  task automatic play_one(input int f, input string req);
    int p, l, r, el, er;
    do_tick(p, l, r);
    model_frame(f, el, er);
    check(p == 1, {req, " R11 one pulse"}, p, 1);
    check(l == el, {req, " left"}, l, el);
    check(r == er, {req, " right"}, r, er);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    mq.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p, l, r, seed;
    seed = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    check(empty == 1'b1, "R3 reset empty", int'(empty), 1);
    check(full == 1'b0, "R2 reset full", int'(full), 0);
    check(low == 1'b1, "R4 reset low", int'(low), 1);
    check(out_valid == 1'b0, "R11 reset valid", int'(out_valid), 0);

    // R7 R8 R9: random frames in every layout with random volume
    for (int f = 0; f < 4; f++) begin
      set_fmt(f);
      for (int k = 0; k < 8; k++) begin
        int n;
        n = (f == 0) ? 1 : (f == 3) ? 4 : 2;
        for (int i = 0; i < n; i++) push(8'($urandom));
        @(negedge clk); volume = 4'($urandom);
        play_one(f, "R7 R8 R9 random");
        check_flags();
      end
    end

    // directed extremes: full-scale negative at max volume, volume zero
    set_fmt(3);
    @(negedge clk); volume = 4'd15;
    push(8'h00); push(8'h80); push(8'hff); push(8'h7f);
    play_one(3, "R9 extreme vol15");
    set_fmt(0);
    @(negedge clk); volume = 4'd0;
    push(8'h7f);
    play_one(0, "R9 volume zero");
    @(negedge clk); volume = 4'd7;
    push(8'h80);
    play_one(0, "R8 negative byte");

    // R10: partial frame is held, then completed
    set_fmt(3);
    push(8'h34); push(8'h12);
    do_tick(p, l, r);
    check(p == 1 && l == 0 && r == 0, "R10 underrun silent", l, 0);
    check(empty == 1'b0, "R10 bytes kept", int'(empty), 0);
    push(8'hcd); push(8'hab);
    play_one(3, "R10 R1 completed frame");
    check_flags();

    // R6: frame cadence at several rates
    do_flush();
    set_fmt(0);
    @(negedge clk); volume = 4'd15;
    for (int i = 0; i < 40; i++) push(8'(i * 3 + 1));
    begin
      int rates [4] = '{128, 64, 32, 0};
      int want [4] = '{8, 4, 2, 0};
      for (int j = 0; j < 4; j++) begin
        int cnt;
        cnt = 0;
        @(negedge clk); rate = 8'(rates[j]);
        for (int t = 0; t < 8; t++) begin
          int el, er;
          do_tick(p, l, r);
          cnt += p;
          if (p == 1) begin
            model_frame(0, el, er);
            check(l == el, "R6 R1 paced value", l, el);
          end
        end
        check(cnt == want[j], "R6 frames per 8 ticks", cnt, want[j]);
      end
    end
    @(negedge clk); rate = 8'd128;

    // R5: flush with simultaneous write
    push(8'h55);
    @(negedge clk); flush = 1'b1; wr_en = 1'b1; wr_data = 8'h66;
    @(negedge clk); flush = 1'b0; wr_en = 1'b0;
    mq.delete();
    check(empty == 1'b1, "R5 flush empties", int'(empty), 1);
    do_tick(p, l, r);
    check(p == 1 && l == 0 && r == 0, "R5 R10 flushed silent", l, 0);

    // R2 R4: fill to capacity, check edges, overflow drop, drain
    set_fmt(3);
    for (int i = 0; i < DEPTH; i++) begin
      push(8'($urandom));
      if (i == DEPTH/4 - 2) check(low == 1'b1, "R4 at 1023", int'(low), 1);
      if (i == DEPTH/4 - 1) check(low == 1'b0, "R4 at 1024", int'(low), 0);
    end
    check(full == 1'b1, "R2 full at capacity", int'(full), 1);
    push(8'hab);
    check(full == 1'b1, "R2 still full", int'(full), 1);
    for (int k = 0; k < DEPTH/4; k++) begin
      play_one(3, "R1 R2 drain");
      if (k == 0 || k == DEPTH/16 * 3 - 1 || k == DEPTH/16 * 3) check_flags();
    end
    check(empty == 1'b1, "R2 overflow byte dropped", int'(empty), 1);
    check_flags();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule